// File: doc/BRIEF.md
# Reference-Rate Lock Qualifier

This block decides whether a frequency synthesizer loop is in lock. It runs on the crystal clock. It makes its own reference-period strobe by dividing that clock by a parameterised ratio, 64 by default. A lock flag is derived from the width of the phase-detector correction pulses. The correction pulse input is high while the charge pump is driving. A pulse that stays high for longer than one crystal period means the loop is off frequency.

The flag falls as soon as one over-long pulse is seen, so loss of lock shows within the reference period in which it happens. Raising the flag is deliberately slow. It rises only after a fixed run of reference periods, eight by default, in each of which every pulse was short. A reference period with no pulse at all counts as a short period.

Once short pulses return, the flag therefore rises between eight and nine reference periods later. The analog charge pump, the oscillator and the loop filter sit outside the block.

Top module: `lockdet_top`

## Requirements
- R1: While reset is active and right after it is released, `lock_o` is 0 and `ref_tick_o` is 0, and the count of good periods starts at zero. With no pulses after reset, the flag first rises at the end of the first period that completes the run of eight.
- R2: `ref_tick_o` is high for exactly one clock cycle out of every 64. It marks the last cycle of a reference period, and the clock edge at the end of that cycle closes the period.
- R3: A correction pulse that is sampled high on exactly one rising clock edge is a short pulse. It does not clear the flag, and it does not break the qualification run.
- R4: A correction pulse that is sampled high on two consecutive rising clock edges is too wide. `lock_o` is 0 right after the second of those edges, in the middle of the reference period.
- R5: `lock_o` rises on the edge that closes the eighth consecutive good reference period, and never at any other edge.
- R6: A too-wide pulse during the qualification run returns the good-period count to zero. After that, eight more complete good periods are needed before the flag rises.
- R7: A reference period with no correction pulse counts as a good period.
- R8: Once `lock_o` is 1, it stays 1 through any number of periods that contain only short pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cp_pulse_i | input | 1 | Correction pulse, high while the charge pump is active |
| ref_tick_o | output | 1 | One-cycle strobe on the last cycle of each reference period |
| lock_o | output | 1 | Lock flag |

## Verification
Each reference period in the bench gets one of three patterns: no pulse, a single-cycle pulse, or a two-cycle pulse. Quiet periods and single-cycle periods must both move the run toward lock, which separates "no pulse" from "short pulse" from "wide pulse". A wide pulse is placed both after lock and partway through a qualification run. The first placement checks the fast mid-period drop. The second checks that the run restarts from zero and that the flag rises on the eighth good period and not on the seventh. The strobe position is checked on every cycle of every period against the period boundaries that the bench derives on its own.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  // Crystal cycles per reference period
  localparam int unsigned REF_DIV_DEF   = 64;
  // Consecutive good periods required to raise the flag
  localparam int unsigned GOOD_RUN_DEF  = 8;
  // Longest pulse, in sampled crystal cycles, still counted as short
  localparam int unsigned SHORT_MAX_DEF = 1;
endpackage

// File: rtl/lockdet_refdiv.sv
module lockdet_refdiv #(
  parameter int unsigned REF_DIV = lockdet_pkg::REF_DIV_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_tick
);
  localparam int unsigned CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

  logic [CW-1:0] div_q, div_d;

  always_comb begin
    if (div_q == LAST) div_d = '0;
    else               div_d = div_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign ref_tick = (div_q == LAST);

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);
  assert_div_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= LAST);
endmodule

// File: rtl/lockdet_width.sv
module lockdet_width #(
  parameter int unsigned SHORT_MAX = lockdet_pkg::SHORT_MAX_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic too_wide
);
  localparam int unsigned WW = $clog2(SHORT_MAX + 2);
  localparam logic [WW-1:0] CAP = WW'(SHORT_MAX);

  logic [WW-1:0] hi_q, hi_d;

  always_comb begin
    if (!pulse)          hi_d = '0;
    else if (hi_q == CAP) hi_d = hi_q;
    else                 hi_d = hi_q + WW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign too_wide = pulse && (hi_q == CAP);

  assert_wide_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    too_wide |-> $past(pulse));
  assert_low_resets_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |=> !too_wide);
endmodule

// File: rtl/lockdet_qual.sv
module lockdet_qual #(
  parameter int unsigned GOOD_RUN = lockdet_pkg::GOOD_RUN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic too_wide,
  output logic lock
);
  localparam int unsigned GW = $clog2(GOOD_RUN + 1);
  localparam logic [GW-1:0] RUN_V  = GW'(GOOD_RUN);
  localparam logic [GW-1:0] RUN_M1 = GW'(GOOD_RUN - 1);

  logic [GW-1:0] good_q, good_d;
  logic          bad_q, bad_d;
  logic          lock_q, lock_d;

  always_comb begin
    good_d = good_q;
    lock_d = lock_q;
    bad_d  = ref_tick ? 1'b0 : (bad_q | too_wide);
    if (too_wide) begin
      good_d = '0;
      lock_d = 1'b0;
    end else if (ref_tick) begin
      if (bad_q) begin
        good_d = '0;
      end else begin
        if (good_q != RUN_V) good_d = good_q + GW'(1);
        if (good_q >= RUN_M1) lock_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      bad_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      good_q <= good_d;
      bad_q  <= bad_d;
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;

  assert_drop_on_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    too_wide |=> !lock);
  assert_rise_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(ref_tick));
  assert_restart_after_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    too_wide |=> (good_q == '0));
  assert_lock_has_full_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (good_q == RUN_V));
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top #(
  parameter int unsigned REF_DIV   = lockdet_pkg::REF_DIV_DEF,
  parameter int unsigned GOOD_RUN  = lockdet_pkg::GOOD_RUN_DEF,
  parameter int unsigned SHORT_MAX = lockdet_pkg::SHORT_MAX_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cp_pulse_i,
  output logic ref_tick_o,
  output logic lock_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       wide;
  logic       tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lockdet_refdiv #(.REF_DIV(REF_DIV)) u_refdiv (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ref_tick (tick)
  );

  lockdet_width #(.SHORT_MAX(SHORT_MAX)) u_width (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pulse    (cp_pulse_i),
    .too_wide (wide)
  );

  lockdet_qual #(.GOOD_RUN(GOOD_RUN)) u_qual (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ref_tick (tick),
    .too_wide (wide),
    .lock     (lock_o)
  );

  assign ref_tick_o = tick;

  assert_reset_outputs_R1: assert property (@(posedge clk)
    !rst_int_n |-> (!lock_o && !ref_tick_o));
endmodule

// File: tb/sim_lockdet_top.sv
`timescale 1ns/1ps
module sim_lockdet_top;
  logic clk;
  logic rst_n;
  logic cp_pulse_i;
  logic ref_tick_o;
  logic lock_o;

  int n_vec;
  int n_bad;
  int model_good;
  bit model_lock;
  bit done;

  localparam int PER = 64;
  localparam int RUN = 8;

  lockdet_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cp_pulse_i (cp_pulse_i),
    .ref_tick_o (ref_tick_o),
    .lock_o     (lock_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // kind 0: quiet, 1: one-cycle pulse, 2: two-cycle pulse
  task automatic run_period(input int kind, input string req);
    for (int i = 0; i < PER; i++) begin
      cp_pulse_i = (kind == 1 && i == 10) || (kind == 2 && (i == 10 || i == 11));
      @(negedge clk);
      check(ref_tick_o == (i == PER - 2), "R2", ref_tick_o, (i == PER - 2));
      if (kind == 2 && i == 11)
        check(lock_o == 1'b0, "R4", lock_o, 0);
    end
    cp_pulse_i = 1'b0;
    if (kind == 2) begin
      model_good = 0;
      model_lock = 1'b0;
    end else begin
      if (model_good < RUN) model_good++;
      if (model_good == RUN) model_lock = 1'b1;
    end
    check(lock_o == model_lock, req, lock_o, model_lock);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cp_pulse_i = 1'b0;
    repeat (3) @(negedge clk);
    check(lock_o == 1'b0, "R1", lock_o, 0);
    check(ref_tick_o == 1'b0, "R1", ref_tick_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(lock_o == 1'b0, "R1", lock_o, 0);
    check(ref_tick_o == 1'b0, "R1", ref_tick_o, 0);
    while (!ref_tick_o) @(negedge clk);
    @(negedge clk);
    model_good = 1;
    model_lock = 1'b0;
    check(lock_o == 1'b0, "R1", lock_o, 0);
  endtask

  task automatic t_quiet_acquire();
    for (int p = 0; p < RUN - 1; p++) run_period(0, "R7");
    check(lock_o == 1'b1, "R5", lock_o, 1);
  endtask

  task automatic t_short_hold();
    for (int p = 0; p < 4; p++) run_period(1, "R8");
    check(lock_o == 1'b1, "R3", lock_o, 1);
  endtask

  task automatic t_wide_drop();
    run_period(2, "R4");
    check(lock_o == 1'b0, "R4", lock_o, 0);
  endtask

  task automatic t_restart();
    for (int p = 0; p < 5; p++) run_period(1, "R3");
    run_period(2, "R6");
    for (int p = 0; p < RUN - 1; p++) run_period(p[0] ? 0 : 1, "R6");
    check(lock_o == 1'b0, "R6", lock_o, 0);
    run_period(1, "R5");
    check(lock_o == 1'b1, "R5", lock_o, 1);
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    done = 1'b0;
    t_reset();
    t_quiet_acquire();
    t_short_hold();
    t_wide_drop();
    t_restart();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule